// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block decides which of six bus masters may drive a shared parallel bus next. Slot 0 is the chip's own internal master; slots 1 to 5 are five external masters. Each slot has its own request input and grant output. A programmable mask places every slot in a high or a low priority group. A round-robin runs inside each group, and the whole low group takes one turn in the rotation of the high group. A fair share therefore reaches both groups, and a heavy requester cannot starve the others.

The next grant is issued while the current master's transaction is running, so the next owner is chosen before the bus is free. A higher-priority request can still take over that pending grant. When a request arrives on an idle bus, the arbiter drives all grants low for one clock and then grants the winner. With no requests pending, the grant stays parked on the last owner. A strap sampled during reset selects whether the arbiter is active. A later write to a disable control can change that choice. With the arbiter inactive, the slot-1 external pins are reused so that an outside arbiter can serve the internal master.

Top module: `bus_rr_arbiter`

## Requirements
- R1: While reset is high and on the first clock after it, all grants are low. The arbiter mode follows `strap_en` as sampled in the last reset cycle, where 1 means active, and `ext_mode` shows the inverse. The park owner and both rotation pointers start at slot 0 (the internal master).
- R2: At most one grant is high in any cycle. The grant vector is `{ext_gnt, int_gnt}`, in which bit i is slot i.
- R3: Inside a group, the grant goes to the first requesting slot found in circular numerical order after the last slot that started a transaction in that group. Slots that are not requesting are skipped.
- R4: Bit i of `prio_hi` places slot i in the high group (1) or the low group (0). The low group holds one position in the high rotation, placed after slot 5. The low-group pointer moves only when a low slot starts a transaction. With the high group {0,1}, the low group {2..5} and every slot requesting, the grants follow the order 1,2,0,1,3,0,1,4,0,1,5,0,1.
- R5: A transaction starts when `bus_idle` falls. The slot granted at that moment becomes the owner. From the second clock after the start, the grant shows the next winner while the bus is still busy.
- R6: A pending grant moves to another slot on the next clock when a slot that ranks earlier in the rotation raises its request.
- R7: When a request rises while `bus_idle` is high, all grants are low on the next clock. On the clock after that, the winner is granted.
- R8: With no requests, the grant stays on the last owner (slot 0 after reset), whether the bus is idle or busy.
- R9: A pulse on `cfg_we` sets the mode from `cfg_dis`, where 0 means active and 1 means inactive. This overrides the strap. Changes to `strap_en` after reset have no effect.
- R10: While the arbiter is inactive, `ext_gnt` is all low. `ext_req0_fwd` carries `int_req`, and `int_gnt` carries `ext_gnt0_in`, each one clock later. While the arbiter is active, `ext_req0_fwd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_en | input | 1 | Mode strap sampled during reset, 1 = arbiter active |
| cfg_we | input | 1 | Write strobe for the disable control |
| cfg_dis | input | 1 | Disable value, 1 = arbiter inactive |
| prio_hi | input | 6 | Group mask, bit i = 1 puts slot i in the high group |
| bus_idle | input | 1 | High when neither the frame nor the ready strobe is asserted |
| int_req | input | 1 | Internal master request (slot 0) |
| ext_req | input | 5 | External master requests, bit j is slot j+1 |
| ext_gnt0_in | input | 1 | Grant from an outside arbiter, used when inactive |
| int_gnt | output | 1 | Grant to the internal master |
| ext_gnt | output | 5 | Grants to the external masters, bit j is slot j+1 |
| ext_req0_fwd | output | 1 | Internal request sent to an outside arbiter when inactive |
| ext_mode | output | 1 | High while the arbiter is inactive (slot-1 pins turned around) |

## Verification
The bench runs the mixed-group case with every slot requesting for thirteen transactions. A design that gave the low group one position per low slot, or that moved the low pointer on every grant, would change the order of that sequence. It checks the dead clock on an idle-bus request and the grant that moves during a busy transaction: a design without the turnaround grants one clock early, and one that updates on grant instead of on bus start never moves the grant ahead. It also raises an earlier-ranked request while a grant is pending, to catch a design that locks in a grant. It lets requests fall away to catch a design that parks on slot 0 instead of on the last owner. Finally it covers the strap against the disable write and the forwarding of slot-1 signals, where a mixed-up polarity shows at once on `ext_mode`.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  // slot index of the internal master, also the reset park owner
  localparam int INT_SLOT = 0;
  // number of external masters in the default configuration
  localparam int DEF_NUM_EXT = 5;
endpackage

// File: rtl/bus_arb_rr_pick.sv
// Circular first-match picker: returns the first set bit after 'last'.
module bus_arb_rr_pick #(
  parameter int N = 7,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] elig,
  input  logic [W-1:0] last,
  output logic         found,
  output logic [W-1:0] pick
);
  always_comb begin
    found = |elig;
    pick  = '0;
    // scan farthest first so the nearest match wins
    for (int k = N; k >= 1; k--) begin
      int p;
      p = int'(last) + k;
      if (p >= N) p = p - N;
      if (elig[p]) pick = W'(p);
    end
  end
endmodule

// File: rtl/bus_arb_mode.sv
// Arbiter mode register and slot-1 pin reuse for an outside arbiter.
module bus_arb_mode (
  input  logic clk,
  input  logic rst,
  input  logic strap_en,
  input  logic cfg_we,
  input  logic cfg_dis,
  input  logic int_req,
  input  logic ext_gnt0_in,
  output logic arb_en,
  output logic ext_req0_fwd,
  output logic fwd_gnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      arb_en       <= strap_en;
      ext_req0_fwd <= 1'b0;
      fwd_gnt      <= 1'b0;
    end else begin
      if (cfg_we) arb_en <= ~cfg_dis;
      ext_req0_fwd <= ~arb_en & int_req;
      fwd_gnt      <= ~arb_en & ext_gnt0_in;
    end
  end
endmodule

// File: rtl/bus_rr_arbiter.sv
module bus_rr_arbiter #(
  parameter int NUM_EXT = bus_arb_pkg::DEF_NUM_EXT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strap_en,
  input  logic               cfg_we,
  input  logic               cfg_dis,
  input  logic [NUM_EXT:0]   prio_hi,
  input  logic               bus_idle,
  input  logic               int_req,
  input  logic [NUM_EXT-1:0] ext_req,
  input  logic               ext_gnt0_in,
  output logic               int_gnt,
  output logic [NUM_EXT-1:0] ext_gnt,
  output logic               ext_req0_fwd,
  output logic               ext_mode
);
  localparam int NSLOT = NUM_EXT + 1;
  localparam int NPOS  = NSLOT + 1;        // high rotation plus low-group token
  localparam int LW    = $clog2(NSLOT);
  localparam int HW    = $clog2(NPOS);
  localparam logic [HW-1:0] LO_TOKEN = HW'(NSLOT);

  logic             arb_en, fwd_gnt;
  logic [NSLOT-1:0] req, req_q, gnt_q, gnt_d, win_oh, park_oh;
  logic [NSLOT-1:0] lo_elig;
  logic [NPOS-1:0]  hi_elig;
  logic [HW-1:0]    hi_last, hi_pick;
  logic [LW-1:0]    lo_last, lo_pick, owner, win_idx, gnt_idx;
  logic             hi_found, lo_found, idle_q, start, new_req;

  bus_arb_mode u_mode (
    .clk(clk), .rst(rst), .strap_en(strap_en), .cfg_we(cfg_we),
    .cfg_dis(cfg_dis), .int_req(int_req), .ext_gnt0_in(ext_gnt0_in),
    .arb_en(arb_en), .ext_req0_fwd(ext_req0_fwd), .fwd_gnt(fwd_gnt)
  );

  assign req = {ext_req, int_req};

  // group eligibility: high slots by themselves, low group as one token
  assign lo_elig = req & ~prio_hi;
  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_hi
      assign hi_elig[gi] = req[gi] & prio_hi[gi];
    end
  endgenerate
  assign hi_elig[NSLOT] = |lo_elig;

  bus_arb_rr_pick #(.N(NPOS), .W(HW)) u_hi_pick (
    .elig(hi_elig), .last(hi_last), .found(hi_found), .pick(hi_pick)
  );
  bus_arb_rr_pick #(.N(NSLOT), .W(LW)) u_lo_pick (
    .elig(lo_elig), .last(lo_last), .found(lo_found), .pick(lo_pick)
  );

  assign win_idx = (hi_pick == LO_TOKEN) ? lo_pick : LW'(hi_pick);

  always_comb begin
    win_oh  = '0;
    park_oh = '0;
    gnt_idx = '0;
    win_oh[win_idx] = 1'b1;
    park_oh[owner]  = 1'b1;
    for (int s = 0; s < NSLOT; s++)
      if (gnt_q[s]) gnt_idx = LW'(s);
  end

  assign start   = idle_q & ~bus_idle;
  assign new_req = bus_idle & |(req & ~req_q);

  // next grant: park, turnaround, or winner
  always_comb begin
    if (!arb_en)                 gnt_d = '0;
    else if (!(hi_found || lo_found)) gnt_d = park_oh;
    else if (new_req)            gnt_d = '0;
    else                         gnt_d = win_oh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q   <= '0;
      req_q   <= '0;
      idle_q  <= 1'b1;
      owner   <= LW'(bus_arb_pkg::INT_SLOT);
      hi_last <= HW'(bus_arb_pkg::INT_SLOT);
      lo_last <= LW'(bus_arb_pkg::INT_SLOT);
    end else begin
      gnt_q  <= gnt_d;
      req_q  <= req;
      idle_q <= bus_idle;
      if (arb_en && start && (gnt_q != '0)) begin
        owner <= gnt_idx;
        if (prio_hi[gnt_idx]) begin
          hi_last <= HW'(gnt_idx);
        end else begin
          hi_last <= LO_TOKEN;
          lo_last <= gnt_idx;
        end
      end
    end
  end

  assign int_gnt  = arb_en ? gnt_q[0] : fwd_gnt;
  assign ext_gnt  = gnt_q[NSLOT-1:1];
  assign ext_mode = ~arb_en;
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
  parameter int NUM_EXT = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_idle,
  input logic               int_req,
  input logic [NUM_EXT-1:0] ext_req,
  input logic               ext_gnt0_in,
  input logic               int_gnt,
  input logic [NUM_EXT-1:0] ext_gnt,
  input logic               ext_req0_fwd,
  input logic               ext_mode
);
  logic [NUM_EXT:0] rq, gv;
  assign rq = {ext_req, int_req};
  assign gv = {ext_gnt, int_gnt};

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gv));

  // R10
  ext_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_mode && $past(ext_mode)) |-> (ext_gnt == '0));

  // R10
  fwd_path_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ext_mode && $past(ext_mode)) |->
      (int_gnt == $past(ext_gnt0_in) && ext_req0_fwd == $past(int_req)));

  // R10
  fwd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ext_mode)) |-> !ext_req0_fwd);

  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_mode && bus_idle && (|(rq & ~$past(rq)))) |=> (gv == '0));

  // R3
  grant_to_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !ext_mode && !$past(ext_mode) && (|$past(rq)))
      |-> ((gv & ~$past(rq)) == '0));

  // R8
  park_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !ext_mode && !$past(ext_mode)
     && !$past(ext_mode, 2) && $past(rq) == '0 && $past(rq, 2) == '0)
      |-> ($stable(gv) && $countones(gv) == 1));
endmodule

bind bus_rr_arbiter bus_arb_chk #(.NUM_EXT(NUM_EXT)) u_chk (
  .clk(clk), .rst(rst), .bus_idle(bus_idle), .int_req(int_req),
  .ext_req(ext_req), .ext_gnt0_in(ext_gnt0_in), .int_gnt(int_gnt),
  .ext_gnt(ext_gnt), .ext_req0_fwd(ext_req0_fwd), .ext_mode(ext_mode)
);

// File: tb/sim_bus_rr_arbiter.sv
module sim_bus_rr_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst, strap_en, cfg_we, cfg_dis, bus_idle, int_req, ext_gnt0_in;
  logic [5:0] prio_hi;
  logic [4:0] ext_req, ext_gnt;
  logic       int_gnt, ext_req0_fwd, ext_mode;
  logic [5:0] gv;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  assign gv = {ext_gnt, int_gnt};

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_rr_arbiter u0 (
    .clk(clk), .rst(rst), .strap_en(strap_en), .cfg_we(cfg_we),
    .cfg_dis(cfg_dis), .prio_hi(prio_hi), .bus_idle(bus_idle),
    .int_req(int_req), .ext_req(ext_req), .ext_gnt0_in(ext_gnt0_in),
    .int_gnt(int_gnt), .ext_gnt(ext_gnt), .ext_req0_fwd(ext_req0_fwd),
    .ext_mode(ext_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic strap);
    rst = 1'b1; strap_en = strap; cfg_we = 1'b0; cfg_dis = 1'b0;
    bus_idle = 1'b1; int_req = 1'b0; ext_req = '0; ext_gnt0_in = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  // one transaction: record owner, run the bus busy, release it
  task automatic do_txn(input int exp_slot, input string tag);
    chk(tag, 32'(gv), 32'(6'b1 << exp_slot));
    bus_idle = 1'b0;
    step(2);
    bus_idle = 1'b1;
    step(1);
  endtask

  task automatic t_reset_park;
    prio_hi = 6'h3F;
    do_reset(1'b1);
    chk("R1 grants low after reset", 32'(gv), 0);
    chk("R1 strap active", 32'(ext_mode), 0);
    step(1);
    chk("R8 park on internal after reset", 32'(gv), 32'h01);
  endtask

  task automatic t_turnaround_rotation;
    ext_req[2] = 1'b1;                        // slot 3 on idle bus
    step(1);
    chk("R7 dead clock on idle request", 32'(gv), 0);
    step(1);
    chk("R7 winner after dead clock", 32'(gv), 32'h08);
    bus_idle = 1'b0;                          // slot 3 starts
    step(1);
    ext_req[0] = 1'b1; ext_req[4] = 1'b1;     // slots 1 and 5, bus busy
    step(1);
    chk("R5 R3 next grant while busy skips slot 4", 32'(gv), 32'h20);
    ext_req[3] = 1'b1;                        // slot 4 ranks before slot 5
    step(1);
    chk("R6 pending grant preempted", 32'(gv), 32'h10);
    bus_idle = 1'b1;
    step(1);
    ext_req = '0;
    step(1);
    chk("R8 park on last owner", 32'(gv), 32'h08);
  endtask

  task automatic t_low_group;
    int seq[13] = '{1, 2, 0, 1, 3, 0, 1, 4, 0, 1, 5, 0, 1};
    prio_hi = 6'b000011;
    do_reset(1'b1);
    int_req = 1'b1; ext_req = 5'h1F;
    step(1);
    chk("R7 dead clock mixed groups", 32'(gv), 0);
    step(1);
    for (int k = 0; k < 13; k++) do_txn(seq[k], "R4 R3 low group shares one slot");
    int_req = 1'b0; ext_req = '0;
    step(2);
  endtask

  task automatic t_disable;
    prio_hi = 6'h3F;
    do_reset(1'b1);
    step(1);
    cfg_we = 1'b1; cfg_dis = 1'b1;
    int_req = 1'b1; ext_gnt0_in = 1'b1; ext_req = 5'h1F;
    step(1);
    cfg_we = 1'b0;
    step(1);
    chk("R9 disable write", 32'(ext_mode), 1);
    chk("R10 external grants low", 32'(ext_gnt), 0);
    chk("R10 request forwarded", 32'(ext_req0_fwd), 1);
    chk("R10 grant taken from pin", 32'(int_gnt), 1);
    ext_gnt0_in = 1'b0;
    step(1);
    chk("R10 grant follows pin low", 32'(int_gnt), 0);
    cfg_we = 1'b1; cfg_dis = 1'b0;
    step(1);
    cfg_we = 1'b0;
    step(1);
    chk("R9 re-enable write", 32'(ext_mode), 0);
    chk("R10 forward quiet when active", 32'(ext_req0_fwd), 0);
    int_req = 1'b0; ext_req = '0;
    step(2);
  endtask

  task automatic t_strap;
    do_reset(1'b0);
    chk("R1 strap low gives inactive", 32'(ext_mode), 1);
    strap_en = 1'b1;
    step(2);
    chk("R9 strap ignored after reset", 32'(ext_mode), 1);
    chk("R10 external grants low on strap", 32'(ext_gnt), 0);
  endtask

  initial begin
    prio_hi = 6'h3F;
    t_reset_park();
    t_turnaround_rotation();
    t_low_group();
    t_disable();
    t_strap();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule